// File: doc/BRIEF.md
# Staged Reset Sequencer

This block collects five reset requests and releases a chip's reset domains in a fixed order. The requests are power-on, an external reset pin, a watchdog time-out, a watchdog clock-loss indication and a software request. Any request pulls the downstream resets low at once, without waiting for a clock edge. Release is counted and synchronous. First the clock-generator reset is freed, in the oscillator domain. The peripheral reset and then the core reset follow, each in the system-clock domain.

Each request is captured by a two-flop shaper in the oscillator domain. The shaper stretches even a very short pulse into at least one full clock of assertion. The shaped requests are merged into one combined reset. The power-on request is special: it is first held for an extra stretch of oscillator cycles before it reaches its shaper, and that stretched form is brought out on its own pin. The software request arrives as a one-cycle pulse in the system-clock domain. It is held until the peripheral reset has taken effect, so the oscillator domain cannot miss it. A cause register records which sources started the most recent reset.

Top module: `rst_stager`

## Requirements
- R1: Requests `rst_ni`, `ext_rst_ni`, `wdt_tmo_ni` and `wdt_clkloss_ni` are active low. While `rst_ni` is low, all four reset outputs are low and `cause_o` reads 5'b00001.
- R2: `por_rst_no` goes high on the 64th oscillator rising edge after `rst_ni` goes high.
- R3: `cg_rst_no` goes high on the 34th oscillator rising edge after the last active request goes high (2 for shaping, 32 for the delay). After power-on, that is the 98th edge after `rst_ni` goes high.
- R4: `perip_rst_no` goes high on the 32nd system-clock rising edge after `cg_rst_no` goes high.
- R5: `core_rst_no` goes high on the 32nd system-clock rising edge after `perip_rst_no` goes high.
- R6: An external, time-out or clock-loss request drives `cg_rst_no`, `perip_rst_no` and `core_rst_no` low with no clock edge needed, and leaves `por_rst_no` high.
- R7: A request much shorter than one oscillator period still produces a complete reset with the timing of R3 to R5.
- R8: A new request during a release countdown forces every released or counting output low at once, and all counts start again from zero.
- R9: A single-cycle high pulse on `sw_rst_i`, sampled on a system-clock edge, produces a complete reset. By the next system-clock edge, `perip_rst_no` is low.
- R10: `cause_o` bit meaning: bit 0 power-on, bit 1 external, bit 2 time-out, bit 3 clock-loss, bit 4 software. On the first oscillator edge of each new combined reset, the register loads the set of sources active at that edge. Only `rst_ni` sets it back to 5'b00001, and it never reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock |
| sys_clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on request, active low |
| ext_rst_ni | input | 1 | External reset pin request, active low |
| wdt_tmo_ni | input | 1 | Watchdog time-out request, active low |
| wdt_clkloss_ni | input | 1 | Watchdog clock-loss request, active low |
| sw_rst_i | input | 1 | Software reset pulse, active high, system-clock domain |
| por_rst_no | output | 1 | Stretched power-on reset, active low |
| cg_rst_no | output | 1 | Clock-generator reset, active low |
| perip_rst_no | output | 1 | Peripheral reset, active low |
| core_rst_no | output | 1 | Core reset, active low |
| cause_o | output | 5 | Sources of the latest reset |

## Verification
A counter stuck or off by one shows up as a release edge that moves by whole clocks. The bench timestamps every release against its own edge counters and compares the result to the exact counts in R2 to R5. A shaper or hold flop that loses a short or cross-domain request shows up at once: the downstream outputs stay high within a fraction of a clock after the request, or the sequence never restarts. A wrong cause capture is visible on `cause_o` from the first oscillator edge after the reset begins, and it stays wrong until the next reset.

// File: rtl/rst_stager_pkg.sv
`timescale 1ns/10ps
package rst_stager_pkg;
  localparam int unsigned NSRC    = 5;
  localparam int unsigned SRC_POR = 0;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_TMO = 2;
  localparam int unsigned SRC_CLK = 3;
  localparam int unsigned SRC_SW  = 4;
  typedef logic [NSRC-1:0] src_vec_t;
  localparam src_vec_t CAUSE_POR = src_vec_t'(1) << SRC_POR;
endpackage

// File: rtl/rst_stager_shaper.sv
`timescale 1ns/10ps
module rst_stager_shaper #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic req_ni,
  output logic req_o
);
  logic [STAGES-1:0] q;

  // async set, clean synchronous release
  always_ff @(posedge clk_i or negedge req_ni) begin
    if (!req_ni) q <= '1;
    else         q <= {q[STAGES-2:0], 1'b0};
  end

  assign req_o = q[STAGES-1];
endmodule

// File: rtl/rst_stager_delay.sv
`timescale 1ns/10ps
module rst_stager_delay #(
  parameter int unsigned CYCLES = 32
) (
  input  logic clk_i,
  input  logic req_ni,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge req_ni) begin
    if (!req_ni) begin
      cnt_q <= '0;
      rst_o <= 1'b1;
    end else if (rst_o) begin
      if (cnt_q == LAST) rst_o <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_stager_cause.sv
`timescale 1ns/10ps
module rst_stager_cause
  import rst_stager_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t src_i,
  output src_vec_t cause_o
);
  logic act, act_q;

  assign act = |src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= CAUSE_POR;
      act_q   <= 1'b1;
    end else begin
      act_q <= act;
      if (act && !act_q) cause_o <= src_i;
    end
  end
endmodule

// File: rtl/rst_stager.sv
`timescale 1ns/10ps
module rst_stager
  import rst_stager_pkg::*;
#(
  parameter int unsigned POR_EXT_CYC = 64,
  parameter int unsigned CG_CYC      = 32,
  parameter int unsigned PERIP_CYC   = 32,
  parameter int unsigned CORE_CYC    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           osc_clk_i,
  input  logic           sys_clk_i,
  input  logic           rst_ni,
  input  logic           ext_rst_ni,
  input  logic           wdt_tmo_ni,
  input  logic           wdt_clkloss_ni,
  input  logic           sw_rst_i,
  output logic           por_rst_no,
  output logic           cg_rst_no,
  output logic           perip_rst_no,
  output logic           core_rst_no,
  output logic [NSRC-1:0] cause_o
);
  logic     por_ext, cg_rst, perip_rst, core_rst, comb_rst;
  logic     sw_hold_q;
  src_vec_t set_n, shaped;

  rst_stager_delay #(.CYCLES(POR_EXT_CYC)) u_por_dly (
    .clk_i(osc_clk_i), .req_ni(rst_ni), .rst_o(por_ext));

  // power-on also seeds every shaper so none starts unknown
  assign set_n[SRC_POR] = ~por_ext;
  assign set_n[SRC_EXT] = ext_rst_ni & rst_ni;
  assign set_n[SRC_TMO] = wdt_tmo_ni & rst_ni;
  assign set_n[SRC_CLK] = wdt_clkloss_ni & rst_ni;
  assign set_n[SRC_SW]  = ~sw_hold_q & rst_ni;

  for (genvar i = 0; i < NSRC; i++) begin : g_shp
    rst_stager_shaper #(.STAGES(SYNC_STAGES)) u_shp (
      .clk_i(osc_clk_i), .req_ni(set_n[i]), .req_o(shaped[i]));
  end

  assign comb_rst = |shaped;

  // hold the one-cycle software pulse until the peripheral reset lands
  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni)        sw_hold_q <= 1'b0;
    else if (sw_rst_i)  sw_hold_q <= 1'b1;
    else if (perip_rst) sw_hold_q <= 1'b0;
  end

  rst_stager_delay #(.CYCLES(CG_CYC)) u_cg_dly (
    .clk_i(osc_clk_i), .req_ni(~comb_rst), .rst_o(cg_rst));

  rst_stager_delay #(.CYCLES(PERIP_CYC)) u_perip_dly (
    .clk_i(sys_clk_i), .req_ni(~cg_rst), .rst_o(perip_rst));

  rst_stager_delay #(.CYCLES(CORE_CYC)) u_core_dly (
    .clk_i(sys_clk_i), .req_ni(~perip_rst), .rst_o(core_rst));

  rst_stager_cause u_cause (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .src_i(shaped), .cause_o(cause_o));

  assign por_rst_no   = ~por_ext;
  assign cg_rst_no    = ~cg_rst;
  assign perip_rst_no = ~perip_rst;
  assign core_rst_no  = ~core_rst;
endmodule

// File: rtl/rst_stager_chk.sv
`timescale 1ns/10ps
module rst_stager_chk (
  input logic       osc_clk_i,
  input logic       sys_clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       sw_rst_i,
  input logic       por_rst_no,
  input logic       cg_rst_no,
  input logic       perip_rst_no,
  input logic       core_rst_no,
  input logic [4:0] cause_o
);
  // R3
  cg_after_por_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !por_rst_no |-> !cg_rst_no);
  // R4
  perip_after_cg_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !cg_rst_no |-> !perip_rst_no);
  // R5
  core_after_perip_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !perip_rst_no |-> !core_rst_no);
  // R5
  core_rise_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> $past(perip_rst_no));
  // R6
  ext_forces_cg_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !ext_rst_ni |-> !cg_rst_no);
  // R9
  sw_reaches_perip_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !perip_rst_no);
  // R10
  cause_nonzero_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    cause_o != 5'b0);
  // R10
  cause_hold_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    cg_rst_no && $past(cg_rst_no) |-> $stable(cause_o));
endmodule

bind rst_stager rst_stager_chk u_chk (
  .osc_clk_i(osc_clk_i), .sys_clk_i(sys_clk_i), .rst_ni(rst_ni),
  .ext_rst_ni(ext_rst_ni), .sw_rst_i(sw_rst_i), .por_rst_no(por_rst_no),
  .cg_rst_no(cg_rst_no), .perip_rst_no(perip_rst_no),
  .core_rst_no(core_rst_no), .cause_o(cause_o));

// File: tb/sim_rst_stager.sv
`timescale 1ns/10ps
module sim_rst_stager;
  logic osc_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic rst_ni = 1'b0, ext_rst_ni = 1'b1, wdt_tmo_ni = 1'b1, wdt_clkloss_ni = 1'b1;
  logic sw_rst_i = 1'b0;
  logic por_rst_no, cg_rst_no, perip_rst_no, core_rst_no;
  logic [4:0] cause_o;

  int checks = 0, failures = 0;
  int osc_p = 0, sys_p = 0;
  int por_at = 0, cg_at_o = 0, cg_at_s = 0, perip_at = 0, core_at = 0;
  bit done = 1'b0;

  // bit0 ext, bit1 time-out, bit2 clock-loss; expected cause = mask << 1
  localparam logic [2:0] VEC [4] = '{3'b001, 3'b010, 3'b100, 3'b011};

  rst_stager u0 (
    .osc_clk_i(osc_clk), .sys_clk_i(sys_clk), .rst_ni(rst_ni),
    .ext_rst_ni(ext_rst_ni), .wdt_tmo_ni(wdt_tmo_ni),
    .wdt_clkloss_ni(wdt_clkloss_ni), .sw_rst_i(sw_rst_i),
    .por_rst_no(por_rst_no), .cg_rst_no(cg_rst_no),
    .perip_rst_no(perip_rst_no), .core_rst_no(core_rst_no), .cause_o(cause_o));

  // 200 MHz oscillator; system clock offset so edges never coincide
  initial forever #2.5 osc_clk = ~osc_clk;
  initial begin
    #1.2;
    forever begin sys_clk = ~sys_clk; #3; end
  end

  always @(posedge osc_clk) osc_p = osc_p + 1;
  always @(posedge sys_clk) sys_p = sys_p + 1;
  always @(posedge por_rst_no)   por_at = osc_p;
  always @(posedge cg_rst_no)    begin cg_at_o = osc_p; cg_at_s = sys_p; end
  always @(posedge perip_rst_no) perip_at = sys_p;
  always @(posedge core_rst_no)  core_at = sys_p;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_core(input string req);
    int n = 0;
    while (core_rst_no !== 1'b1 && n < 3000) begin
      @(negedge sys_clk);
      n++;
    end
    chk({req, " core released"}, int'(core_rst_no === 1'b1), 1);
  endtask

  task automatic seq_chk(input string req, input int ref_o, input int exp_cg);
    wait_core(req);
    if (exp_cg > 0) chk({req, " R3 cg delay"}, cg_at_o - ref_o, exp_cg);
    chk({req, " R4 perip delay"}, perip_at - cg_at_s, 32);
    chk({req, " R5 core delay"}, core_at - perip_at, 32);
  endtask

  initial begin
    int ref_o;
    repeat (10) @(negedge osc_clk);
    // R1 reset state
    chk("R1 outputs low", int'({por_rst_no, cg_rst_no, perip_rst_no, core_rst_no}), 0);
    chk("R1 cause", int'(cause_o), 1);
    rst_ni = 1'b1;
    ref_o = osc_p;
    wait_core("R2");
    chk("R2 por stretch", por_at - ref_o, 64);
    chk("R3 cg after power-on", cg_at_o - ref_o, 98);
    chk("R4 perip after power-on", perip_at - cg_at_s, 32);
    chk("R5 core after power-on", core_at - perip_at, 32);

    // R6 R3 R10: table walk of pin and watchdog requests
    foreach (VEC[i]) begin
      @(negedge osc_clk);
      ext_rst_ni = ~VEC[i][0]; wdt_tmo_ni = ~VEC[i][1]; wdt_clkloss_ni = ~VEC[i][2];
      #1;
      chk("R6 async assert", int'({cg_rst_no, perip_rst_no, core_rst_no}), 0);
      chk("R6 por untouched", int'(por_rst_no), 1);
      repeat (3) @(negedge osc_clk);
      ext_rst_ni = 1'b1; wdt_tmo_ni = 1'b1; wdt_clkloss_ni = 1'b1;
      ref_o = osc_p;
      seq_chk("R3 table", ref_o, 34);
      chk("R10 table cause", int'(cause_o), int'({1'b0, VEC[i], 1'b0}));
    end

    // R7 sub-period glitch
    @(negedge osc_clk);
    #1 ext_rst_ni = 1'b0;
    #0.3 ext_rst_ni = 1'b1;
    ref_o = osc_p;
    #0.2;
    chk("R7 glitch asserts", int'({cg_rst_no, perip_rst_no, core_rst_no}), 0);
    seq_chk("R7", ref_o, 34);
    chk("R7 cause", int'(cause_o), 2);

    // R8 restart during peripheral countdown
    @(negedge osc_clk);
    ext_rst_ni = 1'b0;
    repeat (2) @(negedge osc_clk);
    ext_rst_ni = 1'b1;
    while (cg_rst_no !== 1'b1) @(negedge osc_clk);
    repeat (10) @(negedge sys_clk);
    chk("R8 perip still counting", int'(perip_rst_no), 0);
    #1 wdt_tmo_ni = 1'b0;
    #0.5;
    chk("R8 reassert", int'({cg_rst_no, perip_rst_no, core_rst_no}), 0);
    #0.5 wdt_tmo_ni = 1'b1;
    ref_o = osc_p;
    seq_chk("R8", ref_o, 34);
    chk("R8 cause", int'(cause_o), 4);

    // R9 software pulse
    @(negedge sys_clk);
    sw_rst_i = 1'b1;
    @(negedge sys_clk);
    sw_rst_i = 1'b0;
    chk("R9 sw asserts", int'({cg_rst_no, perip_rst_no, core_rst_no}), 0);
    chk("R9 por untouched", int'(por_rst_no), 1);
    seq_chk("R9", 0, 0);
    chk("R9 cause", int'(cause_o), 16);

    // R10 power-on resets cause; R2 again
    @(negedge osc_clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 cause on power-on", int'(cause_o), 1);
    chk("R1 por low", int'(por_rst_no), 0);
    repeat (3) @(negedge osc_clk);
    rst_ni = 1'b1;
    ref_o = osc_p;
    wait_core("R2 second");
    chk("R2 por stretch again", por_at - ref_o, 64);
    chk("R3 cg again", cg_at_o - ref_o, 98);
    chk("R10 cause kept", int'(cause_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule